// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes as asynchronous serial frames on a single line. The bus side writes a byte, and optionally a ninth bit, into a one-entry holding register. A shift register that the bus cannot see takes the byte from the holding register and sends it out. While one frame is being shifted out, the bus can already park the next byte in the holding register. That byte moves into the shift register as soon as the current frame's stop bit has finished.

The bit rate comes from an 8-bit divisor. The divisor sets a tick, and either 16 or 64 of those ticks make up one bit. Two status outputs describe the state of the transmitter:
- **Holding-register empty flag.** It is set whenever the holding register has been handed over, and it drives a maskable interrupt. It drops only when the bus writes a new byte.
- **Shift-register empty bit.** It shows whether a frame is on the line. It has no interrupt path, so software polls it.

Dropping the transmit enable aborts the transmitter at once.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, with `tx_en` high and no write, the outputs are `ser_out`=1, `shift_empty`=1, `buf_empty`=1, and `irq` equal to `irq_en`.
- R2: A frame is, in order:
  - one low start bit;
  - the 8 data bits, LSB first;
  - when `nine_bit`=1, the `wr_bit9` value that was captured with the write;
  - one high stop bit.
  
  While no frame is active, the line is high.
- R3: Each bit lasts (`baud_div`+1)×16 clocks when `fast_tick`=1, and (`baud_div`+1)×64 clocks when `fast_tick`=0. `shift_empty` stays low for exactly frame-length × bit-time clocks, where the frame length is 10 bits, or 11 bits with `nine_bit`=1.
- R4: A write to an idle transmitter has this timing:
  - in the cycle after the write edge, `buf_empty`=0;
  - at the next edge the byte is loaded, so that `buf_empty`=1, `shift_empty`=0 and the start bit (0) is on `ser_out`.
- R5: A byte written while a frame is active waits in the holding register with `buf_empty`=0. It is loaded after one idle clock: `shift_empty` is high for exactly one cycle between the two frames.
- R6: Only a write clears `buf_empty`; changing `irq_en` leaves it as it is. `irq` is high only when `buf_empty`=1 and `irq_en`=1.
- R7: Driving `tx_en` low has these effects:
  - by the next clock, any frame is aborted: `shift_empty`=1, `ser_out`=1, `buf_empty`=0;
  - any held byte is discarded, and writes made while `tx_en` is low are ignored;
  - raising `tx_en` sets `buf_empty` in the same cycle.
- R8: With `port_en`=0, `ser_out` stays at 1 while the frame still runs internally with its normal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Holding-register write strobe |
| wr_data | input | 8 | Byte to send |
| wr_bit9 | input | 1 | Ninth data bit, captured with the write |
| port_en | input | 1 | Connects the transmitter to the line |
| tx_en | input | 1 | Transmit enable; low aborts and clears |
| nine_bit | input | 1 | Selects 9-bit frames |
| fast_tick | input | 1 | 1: 16 ticks per bit, 0: 64 ticks per bit |
| baud_div | input | 8 | Divisor; one tick every baud_div+1 clocks |
| irq_en | input | 1 | Interrupt mask |
| ser_out | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | buf_empty gated by irq_en |
| shift_empty | output | 1 | No frame in progress |

## Verification
The bench goes after the following corner cases, each with the failure it would expose:
- **Handover timing.** A design that loads the shift register before the stop bit ends, or that leaves more than one idle clock between frames, is caught by the gap check on back-to-back bytes.
- **Ninth-bit mode.** With the mode off, a frame with an extra slot or a stop bit taken from `wr_bit9` fails the frame-length and stop-bit checks.
- **Bit timing.** The x16 and x64 settings with non-zero divisors expose an off-by-one in the tick reload.
- **Disable path.** An abort that leaves the held byte alive, or that accepts writes while disabled, starts a phantom frame after re-enable; the idle check after re-enable sees it.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;

  // number of bit slots in one frame: start + data + optional ninth + stop
  function automatic int unsigned frame_bits(input int unsigned data_w, input logic nine);
    return data_w + 32'd2 + (nine ? 32'd1 : 32'd0);
  endfunction

  // ticks making up one bit time
  function automatic int unsigned tick_span(input int unsigned fast_ovs,
                                            input int unsigned slow_ovs,
                                            input logic fast);
    return fast ? fast_ovs : slow_ovs;
  endfunction

  // clocks per bit for a given divisor
  function automatic int unsigned bit_clocks(input int unsigned div,
                                             input int unsigned ovs);
    return (div + 32'd1) * ovs;
  endfunction

endpackage

// File: rtl/dbuf_uart_tx_baud.sv
module dbuf_uart_tx_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  // held at the reload value while idle so a frame starts on a fresh period
  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run)             cnt_q <= div;
    else if (cnt_q == '0)      cnt_q <= div;
    else                       cnt_q <= cnt_q - 1'b1;
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/dbuf_uart_tx_hold.sv
module dbuf_uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              bit9
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
      bit9 <= 1'b0;
    end else if (!en) begin
      full <= 1'b0;
    end else if (wr) begin
      // a write in the same cycle as a handover refills the register
      full <= 1'b1;
      data <= wr_data;
      bit9 <= wr_bit9;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/dbuf_uart_tx_shift.sv
module dbuf_uart_tx_shift
  import dbuf_uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FAST_OVS = 16,
  parameter int unsigned SLOW_OVS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_bit9,
  input  logic              nine,
  input  logic              fast,
  input  logic              tick,
  output logic              line,
  output logic              busy,
  output logic              bit_done
);
  localparam int unsigned SH_W  = DATA_W + 3;
  localparam int unsigned SUB_W = $clog2(SLOW_OVS);
  localparam int unsigned IDX_W = $clog2(DATA_W + 4);

  logic [SH_W-1:0]  sh_q;
  logic [SUB_W-1:0] sub_q;
  logic [IDX_W-1:0] idx_q;
  logic [SUB_W-1:0] sub_last;
  logic [IDX_W-1:0] idx_last;
  logic             slot9;

  assign sub_last = SUB_W'(tick_span(FAST_OVS, SLOW_OVS, fast) - 1);
  assign idx_last = IDX_W'(frame_bits(DATA_W, nine) - 1);
  assign slot9    = nine ? ld_bit9 : 1'b1;
  assign bit_done = busy && tick && (sub_q == sub_last);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      busy  <= 1'b0;
      sh_q  <= '1;
      sub_q <= '0;
      idx_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      sh_q  <= {1'b1, slot9, ld_data, 1'b0};
      sub_q <= '0;
      idx_q <= '0;
    end else if (busy && tick) begin
      if (sub_q == sub_last) begin
        sub_q <= '0;
        sh_q  <= {1'b1, sh_q[SH_W-1:1]};
        if (idx_q == idx_last) begin
          busy  <= 1'b0;
          idx_q <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign line = busy ? sh_q[0] : 1'b1;
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
  import dbuf_uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned FAST_OVS = 16,
  parameter int unsigned SLOW_OVS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              nine_bit,
  input  logic              fast_tick,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              irq_en,
  output logic              ser_out,
  output logic              buf_empty,
  output logic              irq,
  output logic              shift_empty
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_bit9;
  logic              shift_busy;
  logic              baud_tick;
  logic              bit_done;
  logic              load_evt;
  logic              tx_line;

  // named internal event: holding register handed to the shifter
  assign load_evt = tx_en && hold_full && !shift_busy;

  dbuf_uart_tx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .wr(wr_stb),
    .wr_data(wr_data), .wr_bit9(wr_bit9), .take(load_evt),
    .full(hold_full), .data(hold_data), .bit9(hold_bit9)
  );

  dbuf_uart_tx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .run(shift_busy), .div(baud_div), .tick(baud_tick)
  );

  dbuf_uart_tx_shift #(.DATA_W(DATA_W), .FAST_OVS(FAST_OVS), .SLOW_OVS(SLOW_OVS)) shift_i (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .start(load_evt),
    .ld_data(hold_data), .ld_bit9(hold_bit9), .nine(nine_bit), .fast(fast_tick),
    .tick(baud_tick), .line(tx_line), .busy(shift_busy), .bit_done(bit_done)
  );

  assign ser_out     = port_en ? tx_line : 1'b1;
  assign buf_empty   = tx_en && !hold_full;
  assign irq         = buf_empty && irq_en;
  assign shift_empty = !shift_busy;
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic tx_en,
  input logic port_en,
  input logic irq_en,
  input logic ser_out,
  input logic buf_empty,
  input logic irq,
  input logic shift_empty,
  input logic load_evt
);
  AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) irq |-> buf_empty); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !irq_en |-> !irq); // R6
  AST_EMPTY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && !wr_stb && tx_en) |=> (buf_empty || !tx_en)); // R6
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_en) |=> (!buf_empty || !tx_en)); // R4
  AST_LOAD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_stb) |=> (buf_empty || !tx_en)); // R4
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!tx_en || (!shift_empty && (!ser_out || !port_en)))); // R4
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_empty |-> !load_evt); // R5
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) shift_empty |-> ser_out); // R2
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |=> shift_empty); // R7
  AST_PORT_OFF: assert property (@(posedge clk) disable iff (!rst_n) !port_en |-> ser_out); // R8
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .tx_en(tx_en), .port_en(port_en),
  .irq_en(irq_en), .ser_out(ser_out), .buf_empty(buf_empty), .irq(irq),
  .shift_empty(shift_empty), .load_evt(load_evt)
);

// File: tb/dbuf_uart_tx_tb_top.sv
`timescale 1ns/1ps
module dbuf_uart_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_bit9 = 1'b0;
  logic       port_en = 1'b1;
  logic       tx_en = 1'b1;
  logic       nine_bit = 1'b0;
  logic       fast_tick = 1'b1;
  logic [7:0] baud_div = 8'd0;
  logic       irq_en = 1'b1;
  logic       ser_out, buf_empty, irq, shift_empty;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dbuf_uart_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .port_en(port_en), .tx_en(tx_en), .nine_bit(nine_bit), .fast_tick(fast_tick),
    .baud_div(baud_div), .irq_en(irq_en), .ser_out(ser_out), .buf_empty(buf_empty),
    .irq(irq), .shift_empty(shift_empty)
  );

  // {data, bit9, nine, fast, div}
  localparam logic [18:0] VEC [0:4] = '{
    {8'hA5, 1'b0, 1'b0, 1'b1, 8'd1},
    {8'h3C, 1'b1, 1'b1, 1'b1, 8'd0},
    {8'h81, 1'b1, 1'b0, 1'b1, 8'd2},
    {8'h00, 1'b0, 1'b1, 1'b0, 8'd2},
    {8'hFF, 1'b0, 1'b1, 1'b0, 8'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int i, input logic [7:0] d, input logic b9,
                                   input logic nine);
    if (i == 0) return 1'b0;
    if (i <= 8) return d[i-1];
    if (i == 9 && nine) return b9;
    return 1'b1;
  endfunction

  // called at a negedge; the byte is captured at the following posedge
  task automatic write_byte(input logic [7:0] d, input logic b9);
    wr_stb = 1'b1; wr_data = d; wr_bit9 = b9;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // called at the first negedge of a frame; returns at the first idle negedge
  task automatic capture(input logic [7:0] d, input logic b9, input logic nine,
                         input int bclk, input string req);
    int k;
    int nb;
    k = 0;
    nb = nine ? 11 : 10;
    while (shift_empty == 1'b0 && k < 20000) begin
      if (k % bclk == bclk / 2)
        chk(req, $sformatf("bit %0d of frame", k / bclk), int'(ser_out),
            int'(exp_bit(k / bclk, d, b9, nine)));
      k++;
      @(negedge clk);
    end
    chk("R3", "frame length in clocks", k, nb * bclk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bclk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ser_out after reset", int'(ser_out), 1);
    chk("R1", "shift_empty after reset", int'(shift_empty), 1);
    chk("R1", "buf_empty after reset", int'(buf_empty), 1);
    chk("R1", "irq after reset", int'(irq), 1);

    // table of frames: R2 format, R3 timing, R4 load timing
    for (int v = 0; v < 5; v++) begin
      nine_bit = VEC[v][9]; fast_tick = VEC[v][8]; baud_div = VEC[v][7:0];
      bclk = (int'(VEC[v][7:0]) + 1) * (VEC[v][8] ? 16 : 64);
      write_byte(VEC[v][18:11], VEC[v][10]);
      chk("R4", "buf_empty after write", int'(buf_empty), 0);
      chk("R4", "shift_empty before load", int'(shift_empty), 1);
      @(negedge clk);
      chk("R4", "buf_empty after load", int'(buf_empty), 1);
      chk("R4", "shift_empty after load", int'(shift_empty), 0);
      chk("R4", "start bit", int'(ser_out), 0);
      capture(VEC[v][18:11], VEC[v][10], VEC[v][9], bclk, "R2");
      @(negedge clk);
    end

    // R5 back-to-back handover
    nine_bit = 1'b0; fast_tick = 1'b1; baud_div = 8'd0; bclk = 16;
    write_byte(8'h5A, 1'b0);
    write_byte(8'hC3, 1'b0);
    chk("R5", "second byte held", int'(buf_empty), 0);
    chk("R5", "first frame running", int'(shift_empty), 0);
    capture(8'h5A, 1'b0, 1'b0, bclk, "R5");
    chk("R5", "idle between frames", int'(shift_empty), 1);
    @(negedge clk);
    chk("R5", "second frame after one idle clock", int'(shift_empty), 0);
    capture(8'hC3, 1'b0, 1'b0, bclk, "R5");

    // R6 flag and interrupt masking
    irq_en = 1'b0;
    #1;
    chk("R6", "irq masked", int'(irq), 0);
    chk("R6", "buf_empty kept by mask change", int'(buf_empty), 1);
    irq_en = 1'b1;
    @(negedge clk);
    write_byte(8'h11, 1'b0);
    write_byte(8'h22, 1'b0);
    chk("R6", "irq low while full", int'(irq), 0);
    irq_en = 1'b0;
    @(negedge clk);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R6", "buf_empty not set by irq_en toggle", int'(buf_empty), 0);

    // R7 abort by disable, held byte discarded, writes ignored
    repeat (30) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R7", "shift_empty after abort", int'(shift_empty), 1);
    chk("R7", "line idle after abort", int'(ser_out), 1);
    chk("R7", "buf_empty while disabled", int'(buf_empty), 0);
    write_byte(8'h77, 1'b0);
    tx_en = 1'b1;
    #1;
    chk("R7", "buf_empty on enable", int'(buf_empty), 1);
    repeat (5) @(negedge clk);
    chk("R7", "no frame from discarded data", int'(shift_empty), 1);
    chk("R7", "line idle after re-enable", int'(ser_out), 1);

    // R8 port disabled: line held high, frame still runs
    port_en = 1'b0;
    write_byte(8'h00, 1'b0);
    @(negedge clk);
    chk("R8", "line held high while port off", int'(ser_out), 1);
    chk("R8", "frame running internally", int'(shift_empty), 0);
    begin
      int k;
      k = 0;
      while (shift_empty == 1'b0 && k < 20000) begin
        if (ser_out != 1'b1) chk("R8", "line high during hidden frame", int'(ser_out), 1);
        k++;
        @(negedge clk);
      end
      chk("R8", "hidden frame length", k, 10 * bclk);
    end
    port_en = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule